// File: doc/BRIEF.md
# Horizontal Sync Noise Detector

The block watches a horizontal sync line and counts two kinds of disturbance. The first is a spurious transition close after a leading edge, inside a detection window whose length is programmable. The second is a missing sync pulse, found when no leading edge arrives by the nominal line period plus one window length. The events add into a saturating counter. When the counter exceeds four times a programmable level, a sticky noise flag is raised. The counter covers one two-field frame: it is cleared on every second vertical-sync detection strobe.

Software sets the window length and the noise level through a small write-only register port. The hsync input is asynchronous to the block clock and is synchronized inside the block. A standby or module-stop request returns both registers to their reset values. The flag stays set until software clears it with a one-cycle strobe.

Top module: `hsync_noise_detector`

## Requirements
- R1: While `rst` is high and after it is released, `noise_flag` is low, the event counter is zero, the vsync parity is even, and the window and level registers are both zero.
- R2: A cycle with `stop_req` high sets the window value and the level to zero at the next edge, and it takes precedence over a write in the same cycle. The counter and the flag are not affected.
- R3: A write with `wr_sel`=0 loads `wr_data[5:0]` as the window value; bits 7:6 are ignored. A write with `wr_sel`=1 loads all 8 bits of `wr_data` as the level.
- R4: `hsync_in` passes through two synchronizing flops and one edge flop. A low-to-high edge that arrives while the window is closed opens the window. The window then stays open for the (W+1)*2 cycles after that edge, where W is the window value.
- R5: Each edge of either polarity seen while the window is open adds one noise event. A rising edge inside an open window neither reopens the window nor restarts the line timer.
- R6: Once the first leading edge has been seen, a drop-out event is counted when `line_period` + (W+1)*2 cycles pass without a window-opening edge. The line timer then restarts as if an edge had come `line_period` cycles after the previous one. A window-opening edge in the same cycle cancels the drop-out.
- R7: The 11-bit event counter adds all the events of a cycle (zero to two) and stops at 2047 instead of wrapping.
- R8: `noise_flag` goes high at the edge after a cycle in which the counter is strictly greater than level*4.
- R9: Every second `vsync_det` strobe since reset clears the counter, and events from that cycle are discarded. Odd-numbered strobes leave the counter unchanged.
- R10: `noise_flag` is sticky. Only `flag_clr` or `rst` clears it, a counter clear does not, and a set condition in the same cycle wins over `flag_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Servo clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Standby / module-stop request, resets the registers |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 window, 1 level |
| wr_data | input | 8 | Write data |
| line_period | input | 16 | Nominal line period in clock cycles |
| hsync_in | input | 1 | Asynchronous horizontal sync input |
| vsync_det | input | 1 | One-cycle strobe for each vertical sync detection |
| flag_clr | input | 1 | One-cycle software clear of the noise flag |
| noise_flag | output | 1 | Sticky noise flag |

## Verification
The assertions assume that `vsync_det` and `flag_clr` are single-cycle strobes and that `line_period` changes only at moments where a restart of the drop-out count is acceptable. The stimulus meets this by driving every strobe for exactly one cycle between falling clock edges. It also keeps each sync pulse longer than the programmed window, so a normal trailing edge is never counted as noise. `line_period` changes only while hsync is idle, right before the drop-out and saturation scenarios.

// File: rtl/hsn_pkg.sv
package hsn_pkg;

    localparam int WIN_W  = 6;
    localparam int LVL_W  = 8;
    localparam int WLEN_W = WIN_W + 2;

    localparam logic [WIN_W-1:0] WIN_RST = '0;
    localparam logic [LVL_W-1:0] LVL_RST = '0;

    typedef enum logic {
        REG_WINDOW = 1'b0,
        REG_LEVEL  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [LVL_W-1:0] lvl;
    } cfg_t;

    typedef struct packed {
        logic noise;
        logic drop;
    } evt_t;

    // Window length in cycles: (value + 1) * 2
    function automatic logic [WLEN_W-1:0] window_cycles(input logic [WIN_W-1:0] w);
        return ({2'b00, w} + 1'b1) << 1;
    endfunction

endpackage

// File: rtl/hsn_cfg_regs.sv
module hsn_cfg_regs
    import hsn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_req,
    input  logic       wr_en,
    input  reg_sel_e   wr_sel,
    input  logic [7:0] wr_data,
    output cfg_t       cfg
);

    always_ff @(posedge clk) begin
        if (rst || stop_req) begin
            cfg.win <= WIN_RST;
            cfg.lvl <= LVL_RST;
        end else if (wr_en) begin
            case (wr_sel)
                REG_WINDOW: cfg.win <= wr_data[WIN_W-1:0];
                REG_LEVEL:  cfg.lvl <= wr_data[LVL_W-1:0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/hsn_edge_sync.sv
module hsn_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_async,
    output logic lead_edge,
    output logic any_edge
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[SH_W-2:0], hs_async};
    end

    // shreg[SH_W-2] is the synchronized level, shreg[SH_W-1] its previous value
    assign lead_edge = shreg[SH_W-2] & ~shreg[SH_W-1];
    assign any_edge  = shreg[SH_W-2] ^ shreg[SH_W-1];

endmodule

// File: rtl/hsn_line_timer.sv
module hsn_line_timer
    import hsn_pkg::*;
#(
    parameter int LINE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lead_edge,
    input  logic              any_edge,
    input  logic [WIN_W-1:0]  win_val,
    input  logic [LINE_W-1:0] line_period,
    output evt_t              evt
);

    localparam int TW = LINE_W + 1;

    logic [WLEN_W-1:0] win_rem;
    logic [WLEN_W-1:0] win_len;
    logic [TW-1:0]     line_cnt;
    logic [TW-1:0]     limit;
    logic              armed;
    logic              win_open;
    logic              opening;
    logic              expire;

    assign win_len  = window_cycles(win_val);
    assign win_open = (win_rem != '0);
    assign opening  = lead_edge & ~win_open;
    assign limit    = {1'b0, line_period} + TW'(win_len);
    assign expire   = armed & ~opening & (line_cnt >= limit);

    assign evt.noise = win_open & any_edge;
    assign evt.drop  = expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_rem  <= '0;
            line_cnt <= '0;
            armed    <= 1'b0;
        end else begin
            if (opening)       win_rem <= win_len;
            else if (win_open) win_rem <= win_rem - 1'b1;

            if (opening) begin
                line_cnt <= '0;
                armed    <= 1'b1;
            end else if (expire) begin
                // restart as though the edge had arrived at its predicted place
                line_cnt <= TW'(win_len) + 1'b1;
            end else if (armed && line_cnt != '1) begin
                line_cnt <= line_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hsn_event_acc.sv
module hsn_event_acc
    import hsn_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  logic             vsync_det,
    input  logic             flag_clr,
    input  logic [LVL_W-1:0] level,
    output logic [CNT_W-1:0] count,
    output logic             flag
);

    logic             vs_odd;
    logic             frame_clr;
    logic [CNT_W-1:0] inc;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_nxt;
    logic             over;

    assign frame_clr = vsync_det & vs_odd;
    assign inc       = CNT_W'(evt.noise) + CNT_W'(evt.drop);
    assign sum       = {1'b0, count} + {1'b0, inc};
    assign cnt_nxt   = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    assign over      = 32'(count) > 32'({level, 2'b00});

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            vs_odd <= 1'b0;
            flag   <= 1'b0;
        end else begin
            if (vsync_det) vs_odd <= ~vs_odd;
            count <= frame_clr ? '0 : cnt_nxt;
            flag  <= over | (flag & ~flag_clr);
        end
    end

endmodule

// File: rtl/hsync_noise_detector.sv
module hsync_noise_detector
    import hsn_pkg::*;
#(
    parameter int LINE_W = 16,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_req,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [LINE_W-1:0] line_period,
    input  logic              hsync_in,
    input  logic              vsync_det,
    input  logic              flag_clr,
    output logic              noise_flag
);

    cfg_t             cfg;
    logic             lead_edge;
    logic             any_edge;
    evt_t             evt;
    logic [CNT_W-1:0] evt_cnt;

    hsn_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .stop_req (stop_req),
        .wr_en    (wr_en),
        .wr_sel   (reg_sel_e'(wr_sel)),
        .wr_data  (wr_data),
        .cfg      (cfg)
    );

    hsn_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .hs_async  (hsync_in),
        .lead_edge (lead_edge),
        .any_edge  (any_edge)
    );

    hsn_line_timer #(.LINE_W(LINE_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .lead_edge   (lead_edge),
        .any_edge    (any_edge),
        .win_val     (cfg.win),
        .line_period (line_period),
        .evt         (evt)
    );

    hsn_event_acc #(.CNT_W(CNT_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .vsync_det (vsync_det),
        .flag_clr  (flag_clr),
        .level     (cfg.lvl),
        .count     (evt_cnt),
        .flag      (noise_flag)
    );

endmodule

// File: rtl/hsn_checker.sv
module hsn_checker
    import hsn_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             stop_req,
    input logic             vsync_det,
    input logic             flag_clr,
    input logic             noise_flag,
    input logic [CNT_W-1:0] evt_cnt,
    input cfg_t             cfg
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic vs_par;

    always_ff @(posedge clk) begin
        if (rst)            vs_par <= 1'b0;
        else if (vsync_det) vs_par <= ~vs_par;
    end

    AST_STOP_CLEARS_REGS: assert property (@(posedge clk) disable iff (rst)
        stop_req |=> (cfg.win == '0 && cfg.lvl == '0)); // R2

    AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
        !vsync_det |=> (evt_cnt >= $past(evt_cnt) && (evt_cnt - $past(evt_cnt)) <= 2)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (evt_cnt == CMAX && !vsync_det) |=> (evt_cnt == CMAX)); // R7

    AST_FLAG_ON_OVER: assert property (@(posedge clk) disable iff (rst)
        (32'(evt_cnt) > 32'({cfg.lvl, 2'b00})) |=> noise_flag); // R8

    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (vsync_det && vs_par) |=> (evt_cnt == '0)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (noise_flag && !flag_clr) |=> noise_flag); // R10

endmodule

bind hsync_noise_detector hsn_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stop_req   (stop_req),
    .vsync_det  (vsync_det),
    .flag_clr   (flag_clr),
    .noise_flag (noise_flag),
    .evt_cnt    (evt_cnt),
    .cfg        (cfg)
);

// File: tb/sim_hsync_noise_detector.sv
`timescale 1ns/1ps
module sim_hsync_noise_detector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stop_req = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] line_period = 16'd60;
    logic        hsync_in = 1'b0;
    logic        vsync_det = 1'b0;
    logic        flag_clr = 1'b0;
    logic        noise_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hsync_noise_detector u0 (
        .clk(clk), .rst(rst), .stop_req(stop_req), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .line_period(line_period),
        .hsync_in(hsync_in), .vsync_det(vsync_det), .flag_clr(flag_clr),
        .noise_flag(noise_flag)
    );

    // Behavioural reference model, updated on every rising edge
    int m_s1, m_s2, m_s3, m_wrem, m_elapsed, m_cnt, m_win, m_lvl;
    bit m_armed, m_vodd, m_flag;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_wrem = 0; m_elapsed = 0;
            m_cnt = 0; m_win = 0; m_lvl = 0; m_armed = 0; m_vodd = 0; m_flag = 0;
        end else begin
            int wl, n;
            bit lead, edge_seen, is_open, opens;
            lead      = (m_s2 == 1) && (m_s3 == 0);
            edge_seen = (m_s2 != m_s3);
            wl        = (m_win + 1) * 2;
            is_open   = m_wrem > 0;
            opens     = lead && !is_open;
            n = 0;
            if (is_open && edge_seen) n++;
            if (m_armed && !opens && m_elapsed >= int'(line_period) + wl) begin
                n++;
                m_elapsed = wl;  // incremented below to wl + 1
            end
            m_flag = (m_cnt > 4 * m_lvl) || (m_flag && !flag_clr);
            if (vsync_det && m_vodd) m_cnt = 0;
            else begin
                m_cnt = m_cnt + n;
                if (m_cnt > 2047) m_cnt = 2047;
            end
            if (vsync_det) m_vodd = !m_vodd;
            if (opens) begin
                m_wrem = wl; m_elapsed = 0; m_armed = 1;
            end else begin
                if (is_open) m_wrem--;
                if (m_armed) m_elapsed++;
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(hsync_in);
            if (stop_req) begin
                m_win = 0; m_lvl = 0;
            end else if (wr_en) begin
                if (wr_sel) m_lvl = int'(wr_data);
                else        m_win = int'(wr_data[5:0]);
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (noise_flag !== m_flag) begin
                errors++;
                $display("FAIL R8 R10 model compare at %0t: actual %0b expected %0b",
                         $time, noise_flag, m_flag);
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic vs_pulse();
        vsync_det = 1'b1;
        @(negedge clk);
        vsync_det = 1'b0;
    endtask

    task automatic clr_pulse();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // One 44-cycle line, 12 cycles high, optional low glitch inside the pulse
    task automatic hs_line(input int g_at, input int g_len);
        for (int k = 0; k < 44; k++) begin
            hsync_in = (k < 12) && !(g_len > 0 && k >= g_at && k < g_at + g_len);
            @(negedge clk);
        end
        hsync_in = 1'b0;
    endtask

    initial begin
        tick(5);
        check("R1 flag low after reset", noise_flag, 1'b0);
        rst = 1'b0;
        tick(3);
        check("R1 flag low after release", noise_flag, 1'b0);

        // window 3 (8 cycles), level 2 (threshold 8)
        write_reg(1'b0, 8'h03);
        write_reg(1'b1, 8'h02);
        for (int i = 0; i < 10; i++) hs_line(0, 0);
        check("R4 clean lines give no events", noise_flag, 1'b0);

        for (int i = 0; i < 4; i++) hs_line(2, 1);
        check("R8 eight events not above 4*2", noise_flag, 1'b0);
        hs_line(2, 1);
        check("R5 glitch edges counted, flag set", noise_flag, 1'b1);

        clr_pulse();
        tick(1);
        check("R10 set beats clear while over", noise_flag, 1'b1);
        vs_pulse(); tick(2); vs_pulse(); tick(2);
        check("R10 frame clear keeps flag", noise_flag, 1'b1);
        clr_pulse();
        tick(1);
        check("R10 software clear", noise_flag, 1'b0);

        // level 1 (threshold 4), odd vsync must not clear
        write_reg(1'b1, 8'h01);
        hs_line(2, 1);
        vs_pulse();
        hs_line(2, 1);
        hs_line(2, 1);
        check("R9 odd vsync keeps count", noise_flag, 1'b1);
        vs_pulse();
        clr_pulse();
        tick(1);
        check("R9 even vsync clears count", noise_flag, 1'b0);

        // window 1 (4 cycles), level 0
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, 8'hC1);
        hs_line(5, 1);
        check("R4 R3 edges after window ignored", noise_flag, 1'b0);
        hs_line(3, 1);
        check("R4 R3 edges inside window counted", noise_flag, 1'b1);

        // drop-outs: window 3, level 1
        write_reg(1'b1, 8'h01);
        write_reg(1'b0, 8'h03);
        vs_pulse(); tick(1); vs_pulse();
        clr_pulse();
        hs_line(0, 0);
        tick(40);
        check("R6 single drop-out under threshold", noise_flag, 1'b0);
        tick(300);
        check("R6 repeated drop-outs raise flag", noise_flag, 1'b1);

        // saturation: one drop-out per cycle, level 255 (threshold 1020)
        line_period = 16'd1;
        write_reg(1'b0, 8'h00);
        write_reg(1'b1, 8'hFF);
        vs_pulse(); tick(1); vs_pulse();
        tick(2200);
        clr_pulse();
        tick(1);
        check("R7 counter saturated, flag held", noise_flag, 1'b1);

        // stop request resets level to 0 and window to 0
        line_period = 16'd1000;
        tick(2);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        vs_pulse(); tick(1); vs_pulse();
        clr_pulse();
        tick(2);
        check("R2 flag cleared before test", noise_flag, 1'b0);
        hs_line(1, 1);
        check("R2 level reset to zero by stop", noise_flag, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule